// File: doc/BRIEF.md
# Programmable I2C master channel

This block is one I2C master channel driven by a small command interface. Software fills an internal byte buffer, sets a clock divider, and pulses a start strobe with the target address, the direction, the address mode (7-bit or 10-bit) and a byte count. The channel then produces the whole bus transaction on its own: start, address bytes, repeated start when a 10-bit read needs one, data bytes with acknowledge handling, and stop.

The bus lines are open-drain. The channel drives them only as pull-low enables, and it reads the resolved data line back to collect acknowledges and read data. Received bytes go into the same buffer, in order from entry 0, where the host reads them after the transfer. Status outputs show whether a transfer is running, whether the last one finished, and whether a target refused a byte. Targets that stretch the clock and buses with more than one master are not supported.

Top module: `i2cm_channel`

## Requirements
- R1: After reset, and whenever no transfer runs, `busy`, `scl_oe` and `sda_oe` are 0; `done` and `nack` are 0 after reset.
- R2: Every bus half-period lasts max(`cfg_div`,1)+1 clock cycles, so a `cfg_div` of 0 behaves as 1.
- R3: A transfer opens with a start: SDA pulled while SCL is released for one half-period. Bits go out MSB first, each as one SCL-low half-period and then one SCL-released half-period. `sda_oe` changes one clock after the SCL state changes.
- R4: In 7-bit mode the first byte is `cmd_addr[6:0]` followed by the direction bit (1 = read, 0 = write).
- R5: A 10-bit write sends `11110`, `cmd_addr[9:8]`, 0, then `cmd_addr[7:0]`, then the data bytes.
- R6: A 10-bit read sends the same two bytes as a write. It then makes a repeated start (one SCL-low half and one SCL-released half with SDA released, then a start), sends `11110`, `cmd_addr[9:8]`, 1, and reads the data.
- R7: A write sends `cmd_cnt`+1 bytes (1 to 16) taken from buffer entries 0 upward. During each acknowledge slot the channel releases SDA.
- R8: A read receives `cmd_cnt`+1 bytes and stores them into buffer entries 0 upward, readable on `rd_data` at `rd_idx`. The master acknowledges every byte but the last by pulling SDA, and leaves SDA released on the last.
- R9: A released SDA in the acknowledge slot of any transmitted byte (address or data) ends the transfer with a stop right after that slot and sets `nack`.
- R10: A stop is made of three half-periods: SCL low with SDA pulled, SCL released with SDA pulled, then both released. After it `busy` falls and `done` is set. `done` and `nack` stay until the next accepted start clears them.
- R11: A `cmd_start` or a buffer write (`wr_en`) that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 16 | Half-period divider; half-period = max(div,1)+1 clocks |
| cmd_start | input | 1 | One-cycle strobe that launches a transfer when idle |
| cmd_read | input | 1 | 1 = read transfer, 0 = write transfer |
| cmd_ten | input | 1 | 1 = 10-bit target address, 0 = 7-bit |
| cmd_addr | input | 10 | Target address |
| cmd_cnt | input | 4 | Number of data bytes minus one |
| wr_en | input | 1 | Host buffer write strobe |
| wr_idx | input | 4 | Host buffer write index |
| wr_data | input | 8 | Host buffer write data |
| rd_idx | input | 4 | Host buffer read index |
| rd_data | output | 8 | Buffer entry at `rd_idx` |
| sda_in | input | 1 | Resolved level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| nack | output | 1 | Last transfer was refused by the target |

## Verification
The hardest situation to reach is a refusal in the middle of a burst, and above all the 10-bit read, which needs a correct acknowledge on two address bytes, a repeated start and a third address byte before any data flows. The bench drives a behavioural target that pulls SDA in the slots chosen for each scenario. It acknowledges selected bytes, refuses the address in one case and the second data byte in another, and sends chosen read bytes. A reference model expands the expected half-period sequence and compares both line enables and the status outputs on every clock.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C master channel.
// Assumes: a single master on the bus and targets that do not stretch SCL.
package i2cm_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_START, S_LOW, S_HIGH, S_RSL, S_RSH, S_PL, S_PH, S_PE
    } bus_st_t;

    typedef enum logic [1:0] {
        B_ADR1, B_ADR2, B_ADR3, B_DATA
    } byte_ph_t;

    localparam logic [4:0] TEN_BIT_MARK = 5'b11110;
endpackage

// File: rtl/i2cm_tick.sv
// Half-period timer: pulses tick once every max(div,1)+1 clocks while run is high.
// Assumes: run rises on the cycle a transfer begins; the count restarts whenever run is low.
module i2cm_tick #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    // Clamp a divider of zero so that data can lag SCL by one clock inside a half-period.
    assign lim  = (div == '0) ? DIVW'(1) : div;
    assign tick = run && (cnt == lim);

    // Count clocks inside the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + DIVW'(1);
    end
endmodule

// File: rtl/i2cm_buf.sv
// Byte buffer shared by the host and the bus engine.
// Assumes: the top gates host writes while busy, so the engine is the only writer during a transfer.
module i2cm_buf #(
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [IW-1:0] h_widx,
    input  logic [7:0]    h_wd,
    input  logic [IW-1:0] h_ridx,
    output logic [7:0]    h_rd,
    input  logic          e_we,
    input  logic [IW-1:0] e_widx,
    input  logic [7:0]    e_wd,
    input  logic [IW-1:0] e_ridx,
    output logic [7:0]    e_rd
);
    logic [7:0] mem [DEPTH];

    assign h_rd = mem[h_ridx];
    assign e_rd = mem[e_ridx];

    // Store a byte from the engine or, failing that, from the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (e_we) begin
            mem[e_widx] <= e_wd;
        end else if (h_we) begin
            mem[h_widx] <= h_wd;
        end
    end
endmodule

// File: rtl/i2cm_eng.sv
// Bus engine: sequences start, address bytes, repeated start, data and stop,
// one state per SCL half-period.
// Assumes: tick marks the last clock of each half-period; sda_in is the resolved line level.
module i2cm_eng
    import i2cm_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cmd_start,
    input  logic          cmd_read,
    input  logic          cmd_ten,
    input  logic [9:0]    cmd_addr,
    input  logic [IW-1:0] cmd_last,
    input  logic          sda_in,
    input  logic [7:0]    buf_rd,
    output logic [IW-1:0] buf_ridx,
    output logic          buf_we,
    output logic [IW-1:0] buf_widx,
    output logic [7:0]    buf_wd,
    output logic          busy,
    output logic          done,
    output logic          nack,
    output logic          scl_oe,
    output logic          sda_oe
);
    bus_st_t       st;
    byte_ph_t      ph;
    logic [8:0]    sh;
    logic [3:0]    bitc;
    logic [IW-1:0] bidx, bidx_nx, last_q;
    logic          rd_q, ten_q;
    logic [9:0]    adr_q;
    logic [6:0]    rxs;
    logic          done_q, nack_q, sda_q, sda_next;
    logic          rx_now;

    assign rx_now   = (ph == B_DATA) && rd_q;
    assign bidx_nx  = bidx + IW'(1);
    assign busy     = (st != S_IDLE);
    assign done     = done_q;
    assign nack     = nack_q;
    assign buf_ridx = (ph == B_DATA) ? bidx_nx : '0;
    assign buf_we   = tick && (st == S_HIGH) && rx_now && (bitc == 4'd7);
    assign buf_widx = bidx;
    assign buf_wd   = {rxs, sda_in};
    assign scl_oe   = (st == S_LOW) || (st == S_RSL) || (st == S_PL);
    assign sda_oe   = sda_q;

    // Choose the SDA pull for the current half-period.
    always_comb begin
        case (st)
            S_START, S_PL, S_PH: sda_next = 1'b1;
            S_LOW, S_HIGH:       sda_next = ~sh[8];
            default:             sda_next = 1'b0;
        endcase
    end

    // Advance the transfer one half-period at a time and track status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; ph <= B_ADR1; sh <= '0; bitc <= '0; bidx <= '0;
            last_q <= '0; rd_q <= 1'b0; ten_q <= 1'b0; adr_q <= '0; rxs <= '0;
            done_q <= 1'b0; nack_q <= 1'b0; sda_q <= 1'b0;
        end else begin
            sda_q <= sda_next;
            if (st == S_IDLE) begin
                if (cmd_start) begin
                    rd_q <= cmd_read; ten_q <= cmd_ten; adr_q <= cmd_addr; last_q <= cmd_last;
                    done_q <= 1'b0; nack_q <= 1'b0;
                    ph <= B_ADR1; bitc <= '0; bidx <= '0;
                    sh <= cmd_ten ? {TEN_BIT_MARK, cmd_addr[9:8], 1'b0, 1'b1}
                                  : {cmd_addr[6:0], cmd_read, 1'b1};
                    st <= S_START;
                end
            end else if (tick) begin
                case (st)
                    S_START: st <= S_LOW;
                    S_LOW:   st <= S_HIGH;
                    S_HIGH: begin
                        if (bitc != 4'd8) begin
                            if (rx_now) rxs <= {rxs[5:0], sda_in};
                            sh   <= {sh[7:0], 1'b0};
                            bitc <= bitc + 4'd1;
                            st   <= S_LOW;
                        end else if (!rx_now && sda_in) begin
                            nack_q <= 1'b1;
                            st     <= S_PL;
                        end else begin
                            bitc <= '0;
                            st   <= S_LOW;
                            case (ph)
                                B_ADR1: begin
                                    if (ten_q) begin
                                        ph <= B_ADR2;
                                        sh <= {adr_q[7:0], 1'b1};
                                    end else begin
                                        ph <= B_DATA;
                                        sh <= rd_q ? {8'hFF, last_q == '0} : {buf_rd, 1'b1};
                                    end
                                end
                                B_ADR2: begin
                                    if (rd_q) begin
                                        ph <= B_ADR3;
                                        st <= S_RSL;
                                        sh <= {TEN_BIT_MARK, adr_q[9:8], 1'b1, 1'b1};
                                    end else begin
                                        ph <= B_DATA;
                                        sh <= {buf_rd, 1'b1};
                                    end
                                end
                                B_ADR3: begin
                                    ph <= B_DATA;
                                    sh <= {8'hFF, last_q == '0};
                                end
                                default: begin
                                    if (bidx == last_q) begin
                                        st <= S_PL;
                                    end else begin
                                        bidx <= bidx_nx;
                                        sh   <= rd_q ? {8'hFF, bidx_nx == last_q} : {buf_rd, 1'b1};
                                    end
                                end
                            endcase
                        end
                    end
                    S_RSL: st <= S_RSH;
                    S_RSH: st <= S_START;
                    S_PL:  st <= S_PH;
                    S_PH:  st <= S_PE;
                    default: begin
                        st     <= S_IDLE;
                        done_q <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cm_channel.sv
// Top of the I2C master channel: divider, byte buffer and bus engine.
// Assumes: open-drain lines driven through the *_oe outputs; host buffer writes are honoured only while idle.
module i2cm_channel #(
    parameter int DIVW  = 16,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] cfg_div,
    input  logic            cmd_start,
    input  logic            cmd_read,
    input  logic            cmd_ten,
    input  logic [9:0]      cmd_addr,
    input  logic [IW-1:0]   cmd_cnt,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [7:0]      rd_data,
    input  logic            sda_in,
    output logic            scl_oe,
    output logic            sda_oe,
    output logic            busy,
    output logic            done,
    output logic            nack
);
    logic          tick;
    logic          e_we;
    logic [IW-1:0] e_widx, e_ridx;
    logic [7:0]    e_wd, e_rd;

    i2cm_tick #(.DIVW(DIVW)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div), .tick(tick)
    );

    i2cm_buf #(.DEPTH(DEPTH), .IW(IW)) buf_i (
        .clk(clk), .rst_n(rst_n),
        .h_we(wr_en && !busy), .h_widx(wr_idx), .h_wd(wr_data),
        .h_ridx(rd_idx), .h_rd(rd_data),
        .e_we(e_we), .e_widx(e_widx), .e_wd(e_wd),
        .e_ridx(e_ridx), .e_rd(e_rd)
    );

    i2cm_eng #(.IW(IW)) eng_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_ten(cmd_ten),
        .cmd_addr(cmd_addr), .cmd_last(cmd_cnt), .sda_in(sda_in),
        .buf_rd(e_rd), .buf_ridx(e_ridx), .buf_we(e_we),
        .buf_widx(e_widx), .buf_wd(e_wd),
        .busy(busy), .done(done), .nack(nack),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/i2cm_channel_chk.sv
// Protocol checker bound to the channel top; observes ports only.
module i2cm_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start,
    input logic busy,
    input logic done,
    input logic nack,
    input logic scl_oe,
    input logic sda_oe
);
    // R1: an idle channel leaves both lines released
    a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));
    // R10: completion is never flagged during a transfer
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10: done only rises at the end of a transfer
    a_r10_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    // R9: a refusal flag belongs to a running or finished transfer
    a_r9_nack_owner: assert property (@(posedge clk) disable iff (!rst_n)
        nack |-> (busy || done));
    // R11: a start strobe on an idle channel is taken up
    a_r11_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> busy);
    // R3: SDA is pulled with SCL released only inside a transfer
    a_r3_start_cond: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> busy);
endmodule

bind i2cm_channel i2cm_channel_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .busy(busy),
    .done(done), .nack(nack), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2cm_channel_tb_top.sv
// Bench: a behavioural target plus a per-clock reference of the expected line enables and status.
module i2cm_channel_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd1;
    logic        cmd_start = 1'b0, cmd_read = 1'b0, cmd_ten = 1'b0;
    logic [9:0]  cmd_addr = '0;
    logic [3:0]  cmd_cnt = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0, rd_idx = '0;
    logic [7:0]  wr_data = '0, rd_data;
    logic        scl_oe, sda_oe, busy, done, nack;
    logic        tb_pull = 1'b0;
    logic        sda_in;

    assign sda_in = ~(sda_oe | tb_pull);

    i2cm_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cmd_start(cmd_start),
        .cmd_read(cmd_read), .cmd_ten(cmd_ten), .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .nack(nack)
    );

    typedef struct packed { logic scl; logic sda; logic tp; } seg_t;
    seg_t       segq[$];
    logic [7:0] mem_m [16];
    int n_chk = 0, n_err = 0;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_seg(input bit scl, input bit sda, input bit tp);
        seg_t s;
        s.scl = scl; s.sda = sda; s.tp = tp;
        segq.push_back(s);
    endtask
    task automatic m_start();
        push_seg(0, 1, 0);
    endtask
    task automatic m_rstart();
        push_seg(1, 0, 0); push_seg(0, 0, 0); push_seg(0, 1, 0);
    endtask
    task automatic m_stop();
        push_seg(1, 1, 0); push_seg(0, 1, 0); push_seg(0, 0, 0);
    endtask
    task automatic m_tx(input logic [7:0] b, input bit ack);
        for (int i = 7; i >= 0; i--) begin
            push_seg(1, ~b[i], 0); push_seg(0, ~b[i], 0);
        end
        push_seg(1, 0, ack); push_seg(0, 0, ack);
    endtask
    task automatic m_rx(input logic [7:0] b, input bit last);
        for (int i = 7; i >= 0; i--) begin
            push_seg(1, 0, ~b[i]); push_seg(0, 0, ~b[i]);
        end
        push_seg(1, !last, 0); push_seg(0, !last, 0);
    endtask

    // Launch a transfer and compare every clock against the expanded segment list.
    task automatic run_xfer(input int div, input bit rd, input bit ten, input int addr,
                            input int cnt, input bit exp_nack, input string tag, input int inject_k);
        int h, n, mism, act_v, exp_v;
        bit e_scl, e_sda, e_busy;
        h = ((div == 0) ? 1 : div) + 1;
        mism = 0; act_v = 0; exp_v = 0;
        @(negedge clk);
        cfg_div = 16'(div); cmd_read = rd; cmd_ten = ten; cmd_addr = 10'(addr);
        cmd_cnt = 4'(cnt - 1); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        n = segq.size() * h;
        for (int k = 0; k < n + 2; k++) begin
            e_busy = (k < n);
            e_scl  = (k < n) ? segq[k / h].scl : 1'b0;
            e_sda  = (k == 0) ? 1'b0 : (((k - 1) < n) ? segq[(k - 1) / h].sda : 1'b0);
            if ({scl_oe, sda_oe, busy, done} != {e_scl, e_sda, e_busy, !e_busy}) begin
                if (mism == 0) begin
                    act_v = {k, scl_oe, sda_oe, busy, done};
                    exp_v = {k, e_scl, e_sda, e_busy, !e_busy};
                end
                mism++;
            end
            tb_pull = (k < n) ? segq[k / h].tp : 1'b0;
            if (k == inject_k) begin
                cmd_start = 1'b1; cmd_addr = 10'h3FF; wr_en = 1'b1; wr_idx = 4'd0; wr_data = 8'h5A;
            end else begin
                cmd_start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        tb_pull = 1'b0; cmd_start = 1'b0; wr_en = 1'b0;
        check(mism == 0, tag, "waveform {cycle,scl,sda,busy,done}", act_v, exp_v);
        check(nack == exp_nack, tag, "nack status", int'(nack), int'(exp_nack));
        segq.delete();
    endtask

    task automatic host_wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mem_m[idx] = d;
    endtask

    task automatic host_rd(input int idx, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_idx = 4'(idx);
        #1;
        check(rd_data == exp, tag, "buffer readback", int'(rd_data), int'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({busy, scl_oe, sda_oe, done, nack} == 5'b0, "R1", "reset outputs",
              int'({busy, scl_oe, sda_oe, done, nack}), 0);
        for (int i = 0; i < 16; i++) host_wr(i, 8'(8'h10 + i * 7));

        // R4 R7 R3 R10: 7-bit single-byte write
        m_start(); m_tx({7'h52, 1'b0}, 1); m_tx(mem_m[0], 1); m_stop();
        run_xfer(1, 0, 0, 'h52, 1, 0, "R4/R7/R3/R10", -1);

        // R7 R11: multi-byte write with a stray start and host write mid-transfer
        m_start(); m_tx({7'h1B, 1'b0}, 1);
        for (int i = 0; i < 3; i++) m_tx(mem_m[i], 1);
        m_stop();
        run_xfer(2, 0, 0, 'h1B, 3, 0, "R7/R11", 20);
        host_rd(0, mem_m[0], "R11");

        // R8: 7-bit multi-byte read
        m_start(); m_tx({7'h33, 1'b1}, 1);
        m_rx(8'hA5, 0); m_rx(8'h3C, 0); m_rx(8'h81, 1); m_stop();
        run_xfer(1, 1, 0, 'h33, 3, 0, "R8/R4", -1);
        mem_m[0] = 8'hA5; mem_m[1] = 8'h3C; mem_m[2] = 8'h81;
        host_rd(0, 8'hA5, "R8"); host_rd(1, 8'h3C, "R8"); host_rd(2, 8'h81, "R8");

        // R5: 10-bit write, two data bytes
        m_start(); m_tx(8'hF4, 1); m_tx(8'hC7, 1); m_tx(mem_m[0], 1); m_tx(mem_m[1], 1); m_stop();
        run_xfer(3, 0, 1, 'h2C7, 2, 0, "R5/R2", -1);

        // R6: 10-bit read with repeated start
        m_start(); m_tx(8'hF2, 1); m_tx(8'h5E, 1); m_rstart(); m_tx(8'hF3, 1);
        m_rx(8'h96, 0); m_rx(8'h0F, 1); m_stop();
        run_xfer(1, 1, 1, 'h15E, 2, 0, "R6", -1);
        host_rd(0, 8'h96, "R6"); host_rd(1, 8'h0F, "R6");
        mem_m[0] = 8'h96; mem_m[1] = 8'h0F;

        // R9: address refused
        m_start(); m_tx(8'h80, 0); m_stop();
        run_xfer(1, 0, 0, 'h40, 1, 1, "R9 address", -1);

        // R9: second data byte refused inside a four-byte burst
        m_start(); m_tx({7'h11, 1'b0}, 1); m_tx(mem_m[0], 1); m_tx(mem_m[1], 0); m_stop();
        run_xfer(1, 0, 0, 'h11, 4, 1, "R9 data", -1);

        // R2 R10: divider of zero behaves as one; nack cleared by the new start
        m_start(); m_tx({7'h52, 1'b0}, 1); m_tx(mem_m[0], 1); m_stop();
        run_xfer(0, 0, 0, 'h52, 1, 0, "R2/R10", -1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule